// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block produces the fixed initialization command stream that a DDR2 memory needs after power-up, for one or two chip selects. Each command leaves as a packed 32-bit direct-command word on a valid/ready interface that feeds the command port of a memory controller. A downstream consumer accepts a word when it raises ready.

A start pulse opens a run. The block first drops its refresh-enable output so that the controller keeps auto-refresh off, then walks a twelve-step list for chip 0 and, when two chips are configured, the same list for chip 1. One clock after the last word is accepted it pulses done and raises refresh-enable together. Between commands it leaves a parameterised minimum number of idle clocks. The CAS latency, burst length and write-recovery code that fill the mode register come from parameters.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, cmd_valid_o, done_o and refresh_enable_o are all 0.
- R2: A command word holds the command kind in bits [27:24] (7 = NOP/deselect, 1 = precharge all, 5 = auto-refresh, 0 = mode-register write), the chip select in bit 20 (0 = chip 0, 1 = chip 1), the mode-register number in bits [18:16] (0 = MR, 1..3 = EMR1..EMR3) and the register value in bits [15:0]; every other bit is 0.
- R3: For each chip the words come in this fixed order of twelve: NOP, precharge all, EMR2 write, EMR3 write, EMR1 write (device DLL on), MR write with DLL reset, precharge all, auto-refresh, auto-refresh, MR write without DLL reset, EMR1 write with OCD default, EMR1 write with OCD exit.
- R4: The MR value is WR_CODE<<9 | CAS_LAT<<4 | burst code (2 for burst 4, 3 for burst 8), with bit 8 also set in the DLL-reset write; defaults give 0x542 with DLL reset and 0x442 without.
- R5: EMR1 carries 0x400 for normal operation (DQS complement off) and 0x780 for OCD default; EMR2 and EMR3 carry 0.
- R6: A word is consumed only in a cycle where cmd_valid_o and cmd_ready_i are both 1; while valid is high and ready is low, valid and the word stay unchanged.
- R7: After each accepted word that is not the last, cmd_valid_o stays low for exactly GAP_CYCLES clocks and rises on the next one.
- R8: With NUM_CHIPS = 2 all twelve chip-0 words are accepted before the first chip-1 word, 24 in total; with NUM_CHIPS = 1 exactly twelve words appear, all with bit 20 at 0.
- R9: refresh_enable_o is 0 from the cycle after start until the run ends; done_o is a one-cycle pulse in the cycle after the last accept, refresh_enable_o rises in that same cycle and stays 1 until the next start.
- R10: A start pulse while a run is in progress is ignored; the run continues unchanged.
- R11: cmd_valid_o first rises in the cycle after start_i is sampled high in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a run when idle |
| cmd_ready_i | input | 1 | Consumer accepts the presented word |
| cmd_valid_o | output | 1 | A command word is presented |
| cmd_word_o | output | 32 | Packed direct-command word |
| refresh_enable_o | output | 1 | Auto-refresh may run |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
Every result is tied to the edge that causes it: the first word is due one clock after start is sampled, the next word GAP_CYCLES+1 clocks after an accept, and done with refresh-enable one clock after the final accept. The bench drives inputs and samples outputs on the falling edge, keeps its own count of clocks since the last accept, and compares the cycle in which valid reappears against that count. A stalled word is compared with its own earlier copy on each falling edge until ready comes, and each new word is compared with a value built by a bench function from the list in R3 to R5.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    KIND_MRW  = 4'd0,
    KIND_PALL = 4'd1,
    KIND_AREF = 4'd5,
    KIND_NOP  = 4'd7
  } cmd_kind_e;

  localparam int unsigned STEPS_PER_CHIP = 12;
  localparam int unsigned STEP_W         = $clog2(STEPS_PER_CHIP);

  function automatic logic [31:0] pack_cmd(cmd_kind_e kind, logic chip,
                                           logic [2:0] mreg, logic [15:0] val);
    return {4'b0, kind, 3'b0, chip, 1'b0, mreg, val};
  endfunction

endpackage

// File: rtl/ddr2_cmd_rom.sv
module ddr2_cmd_rom
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CAS_LAT   = 4,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned WR_CODE   = 2
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic              chip_i,
  output logic [31:0]       word_o
);
  localparam logic [15:0] BL_CODE    = (BURST_LEN == 8) ? 16'd3 : 16'd2;
  localparam logic [15:0] MR_RUN     = 16'((WR_CODE << 9) | (CAS_LAT << 4)) | BL_CODE;
  localparam logic [15:0] MR_DLLRST  = MR_RUN | 16'h0100;
  localparam logic [15:0] EMR1_RUN   = 16'h0400;
  localparam logic [15:0] EMR1_OCD   = EMR1_RUN | 16'h0380;

  always_comb begin
    unique case (step_i)
      4'd0:    word_o = pack_cmd(KIND_NOP,  chip_i, 3'd0, 16'h0);
      4'd1:    word_o = pack_cmd(KIND_PALL, chip_i, 3'd0, 16'h0);
      4'd2:    word_o = pack_cmd(KIND_MRW,  chip_i, 3'd2, 16'h0);
      4'd3:    word_o = pack_cmd(KIND_MRW,  chip_i, 3'd3, 16'h0);
      4'd4:    word_o = pack_cmd(KIND_MRW,  chip_i, 3'd1, EMR1_RUN);
      4'd5:    word_o = pack_cmd(KIND_MRW,  chip_i, 3'd0, MR_DLLRST);
      4'd6:    word_o = pack_cmd(KIND_PALL, chip_i, 3'd0, 16'h0);
      4'd7:    word_o = pack_cmd(KIND_AREF, chip_i, 3'd0, 16'h0);
      4'd8:    word_o = pack_cmd(KIND_AREF, chip_i, 3'd0, 16'h0);
      4'd9:    word_o = pack_cmd(KIND_MRW,  chip_i, 3'd0, MR_RUN);
      4'd10:   word_o = pack_cmd(KIND_MRW,  chip_i, 3'd1, EMR1_OCD);
      4'd11:   word_o = pack_cmd(KIND_MRW,  chip_i, 3'd1, EMR1_RUN);
      default: word_o = pack_cmd(KIND_NOP,  chip_i, 3'd0, 16'h0);
    endcase
  end
endmodule

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
  parameter int unsigned GAP_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic last_o
);
  generate
    if (GAP_CYCLES == 0) begin : g_nogap
      assign last_o = 1'b1;
    end else begin : g_gap
      localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (load_i)        cnt_q <= CNT_W'(GAP_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end

      assign last_o = (cnt_q == CNT_W'(1));

      // R7: a load always starts a non-empty wait
      assert_load_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q != '0));
    end
  endgenerate
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned NUM_CHIPS  = 2,
  parameter int unsigned CAS_LAT    = 4,
  parameter int unsigned BURST_LEN  = 4,
  parameter int unsigned WR_CODE    = 2,
  parameter int unsigned GAP_CYCLES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        cmd_ready_i,
  output logic        cmd_valid_o,
  output logic [31:0] cmd_word_o,
  output logic        refresh_enable_o,
  output logic        done_o
);
  localparam logic              LAST_CHIP = (NUM_CHIPS > 1) ? 1'b1 : 1'b0;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_CHIP - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic              chip_q;
  logic              done_q, refresh_q;
  logic              accept, last_cmd, gap_last;

  assign accept   = (state_q == S_ISSUE) && cmd_ready_i;
  assign last_cmd = (step_q == LAST_STEP) && (chip_q == LAST_CHIP);

  ddr2_cmd_rom #(
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .WR_CODE(WR_CODE)
  ) u_rom (
    .step_i(step_q), .chip_i(chip_q), .word_o(cmd_word_o)
  );

  ddr2_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept && !last_cmd), .last_o(gap_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      step_q    <= '0;
      chip_q    <= 1'b0;
      done_q    <= 1'b0;
      refresh_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q   <= S_ISSUE;
          step_q    <= '0;
          chip_q    <= 1'b0;
          refresh_q <= 1'b0;
        end
        S_ISSUE: if (accept) begin
          if (last_cmd) begin
            state_q   <= S_IDLE;
            done_q    <= 1'b1;
            refresh_q <= 1'b1;
          end else begin
            state_q <= (GAP_CYCLES == 0) ? S_ISSUE : S_WAIT;
            if (step_q == LAST_STEP) begin
              step_q <= '0;
              chip_q <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        S_WAIT: if (gap_last) state_q <= S_ISSUE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid_o      = (state_q == S_ISSUE);
  assign done_o           = done_q;
  assign refresh_enable_o = refresh_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

  assert_refresh_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !refresh_enable_o);

  assert_done_refresh_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(refresh_enable_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  generate
    if (GAP_CYCLES > 0) begin : g_gap_chk
      assert_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && cmd_ready_i) |=> !cmd_valid_o);
    end
    if (NUM_CHIPS == 1) begin : g_one_chk
      assert_single_chip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> !cmd_word_o[20]);
    end
  endgenerate
endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic start1 = 1'b0, ready1 = 1'b0;
  logic valid, done, refr, valid1, done1, refr1;
  logic [31:0] word, word1;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_init_seq #(.NUM_CHIPS(2), .GAP_CYCLES(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_ready_i(ready),
    .cmd_valid_o(valid), .cmd_word_o(word), .refresh_enable_o(refr), .done_o(done));

  ddr2_init_seq #(.NUM_CHIPS(1), .GAP_CYCLES(GAP)) u_dut_one (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .cmd_ready_i(ready1),
    .cmd_valid_o(valid1), .cmd_word_o(word1), .refresh_enable_o(refr1), .done_o(done1));

  function automatic logic [31:0] exp_word(input int chip, input int idx);
    logic [3:0] k; logic [2:0] m; logic [15:0] a;
    k = 4'd0; m = 3'd0; a = 16'h0;
    case (idx)
      0: k = 4'd7;
      1: k = 4'd1;
      2: m = 3'd2;
      3: m = 3'd3;
      4: begin m = 3'd1; a = 16'h0400; end
      5: a = 16'h0542;
      6: k = 4'd1;
      7: k = 4'd5;
      8: k = 4'd5;
      9: a = 16'h0442;
      10: begin m = 3'd1; a = 16'h0780; end
      11: begin m = 3'd1; a = 16'h0400; end
      default: k = 4'hF;
    endcase
    return {4'h0, k, 3'b0, chip[0], 1'b0, m, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Full two-chip run on u_dut; rnd selects random ready, else always ready.
  task automatic run_main(input bit rnd, input bit restart_mid);
    int n = 0, since = 0, cyc = 0;
    bit seen = 0, stall = 0, ref_bad = 0, got_done = 0, chip1_early = 0;
    logic [31:0] prev_w = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(valid === 1'b1, "R11 valid after start", 32'(valid), 32'd1);
    check(refr === 1'b0, "R9 refresh off after start", 32'(refr), 32'd0);
    while (cyc < 2000) begin
      cyc++;
      if (stall) check(valid === 1'b1 && word === prev_w, "R6 word held under stall", word, prev_w);
      if (valid && !seen) begin
        if (n > 0) check(since == GAP + 1, "R7 gap before next word", 32'(since), 32'(GAP + 1));
        check(word === exp_word(n / 12, n % 12), "R2 R3 R4 R5 word", word, exp_word(n / 12, n % 12));
        if (n < 12 && word[20]) chip1_early = 1;
        seen = 1;
      end
      if (done) begin
        check(n == 24, "R8 words per run", 32'(n), 32'd24);
        check(refr === 1'b1, "R9 refresh with done", 32'(refr), 32'd1);
        got_done = 1;
        break;
      end
      if (refr) ref_bad = 1;
      start = (restart_mid && n == 5 && seen) ? 1'b1 : 1'b0; // R10
      ready = rnd ? (($urandom % 3) != 0) : 1'b1;
      stall = 0;
      if (valid && ready) begin n++; since = 0; seen = 0; end
      else if (valid) begin stall = 1; prev_w = word; end
      @(negedge clk);
      start = 1'b0;
      since++;
    end
    check(got_done, "R9 done reached", 32'(got_done), 32'd1);
    check(!ref_bad, "R9 refresh stays off in run", 32'(ref_bad), 32'd0);
    check(!chip1_early, "R8 chip0 list first", 32'(chip1_early), 32'd0);
    ready = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R9 done is one pulse", 32'(done), 32'd0);
    check(refr === 1'b1, "R9 refresh stays on", 32'(refr), 32'd1);
    check(valid === 1'b0, "R8 no extra word", 32'(valid), 32'd0);
  endtask

  task automatic run_one();
    int n = 0, cyc = 0;
    bit seen = 0;
    @(negedge clk) start1 = 1'b1;
    @(negedge clk) start1 = 1'b0;
    ready1 = 1'b1;
    while (cyc < 500 && !done1) begin
      cyc++;
      if (valid1 && !seen) begin
        check(word1 === exp_word(0, n), "R8 single chip word", word1, exp_word(0, n));
        seen = 1;
      end
      if (valid1) begin n++; seen = 0; end
      @(negedge clk);
    end
    check(done1 === 1'b1 && n == 12, "R8 single chip count", 32'(n), 32'd12);
    check(refr1 === 1'b1, "R9 single chip refresh on", 32'(refr1), 32'd1);
    ready1 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R1 valid at reset", 32'(valid), 32'd0);
    check(done === 1'b0, "R1 done at reset", 32'(done), 32'd0);
    check(refr === 1'b0, "R1 refresh at reset", 32'(refr), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(valid === 1'b0 && refr === 1'b0, "R1 idle after reset", 32'(valid), 32'd0);
    run_main(1'b0, 1'b0);
    run_main(1'b1, 1'b1);
    run_main(1'b1, 1'b0);
    run_one();
    summary();
  end
endmodule